// File: doc/BRIEF.md
# Pivot Routing and Retirement Unit

This unit sits between the two halves of a sparse LU factorization engine. One half handles the lower-triangular part of the matrix and the other the upper-triangular part. Pivot selection produces row exchanges, and the unit keeps them in a permutation table. Every matrix element that enters is given a translated row index from that table. The unit then classifies the element and sends it one of three ways: straight to an update lane, into a holding queue when the row exchange moves it to the other triangular half, or out on a retirement stream when the current factorization step can no longer change it.

Held elements leave the queue strictly in the order they arrived. The element at the head is forwarded only when its destination lane signals readiness. A step counter, advanced by a pulse from the factorization controller, sets how far the factorization has progressed. Retirement decisions are based on that counter.

Top module: `pivot_route_unit`

## Requirements
- R1: After reset the permutation table is the identity, the step counter is zero, no lane output and no retirement output is valid, and `in_ready` is high.
- R2: An element accepted at a cycle edge is reported with translated row `perm[in_row]`. A pivot record (`pv_we` with indices `pv_a`, `pv_b`) exchanges `perm[pv_a]` and `perm[pv_b]` at one edge, and elements accepted at that same edge still use the table as it was before the exchange.
- R3: A forwarded element appears one cycle after the decision on exactly one bit of `out_vld`. The lane number is the low log2(LANES) bits of the translated row, and at most one `out_vld` bit is ever high.
- R4: An element counts as lower-triangular when its row is greater than its column, and as upper-triangular otherwise. An element whose class under the translated row differs from its class under the raw row is a crossing element. It goes into the holding queue, and no lane output is produced in the cycle after it is accepted.
- R5: Held elements leave in arrival order, with `out_cross` = 1. The head element leaves only in a cycle where its lane's `lane_rdy` bit is high. A head that is blocked also blocks every element behind it.
- R6: When a direct element and a ready head of the queue compete in the same cycle, the direct element takes the lane output and the head waits.
- R7: An element whose translated row and column are both less than the step counter is retired instead. It appears on `ret_vld`/`ret_row`/`ret_col`/`ret_data` one cycle after acceptance, and it is neither queued nor sent to a lane. This check comes before the crossing check.
- R8: When the holding queue holds HOLD_DEPTH (16) elements, `in_ready` is low and an element offered on `in_valid` is not accepted. Nothing is produced for it.
- R9: Each `step_inc` pulse raises the step counter by one, and the counter saturates at N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming element valid |
| in_ready | output | 1 | Unit can accept an element |
| in_row | input | IW | Raw row index of element |
| in_col | input | IW | Column index of element |
| in_data | input | DW | Element value |
| pv_we | input | 1 | Pivot record write (swap) |
| pv_a | input | IW | First permutation index to swap |
| pv_b | input | IW | Second permutation index to swap |
| step_inc | input | 1 | Advance factorization step |
| lane_rdy | input | LANES | Per-lane readiness for held elements |
| out_vld | output | LANES | One-hot lane output valid |
| out_row | output | IW | Translated row of forwarded element |
| out_col | output | IW | Column of forwarded element |
| out_data | output | DW | Value of forwarded element |
| out_cross | output | 1 | Forwarded element came from the holding queue |
| ret_vld | output | 1 | Retirement output valid |
| ret_row | output | IW | Translated row of retired element |
| ret_col | output | IW | Column of retired element |
| ret_data | output | DW | Value of retired element |

## Verification
The bench keeps its own permutation, queue and step model and checks every cycle against it across sweeps of row and column pairs, before and after row exchanges.

It fills the queue to capacity. A design with a wrong capacity test would either drop an element or accept one too many, and the drain order would then not match. It holds a head element whose lane is not ready while another lane is ready. A design that skipped the blocked head would send the queued elements out of order.

It also sets a direct element against a ready head in the same cycle, where a wrong priority shows up as a cross-flagged output. It sweeps elements on both sides of the step boundary. A design that compared with the raw row instead of the translated one, or used less-or-equal in the retirement test, would retire the wrong elements.

// File: rtl/pvr_pkg.sv
package pvr_pkg;

    // Routing decision for one incoming element
    typedef enum logic [1:0] {
        RT_DIRECT = 2'd0,
        RT_HOLD   = 2'd1,
        RT_RETIRE = 2'd2
    } route_e;

endpackage

// File: rtl/pvr_perm_table.sv
module pvr_perm_table #(
    parameter  int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_en,
    input  logic [IW-1:0] sw_a,
    input  logic [IW-1:0] sw_b,
    input  logic [IW-1:0] rd_idx,
    output logic [IW-1:0] rd_val
);

    logic [IW-1:0] tab_q [N];
    logic [IW-1:0] tab_d [N];

    always_comb begin
        tab_d = tab_q;
        if (sw_en) begin
            tab_d[sw_a] = tab_q[sw_b];
            tab_d[sw_b] = tab_q[sw_a];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) tab_q[i] <= IW'(i);
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rd_val = tab_q[rd_idx];

endmodule

// File: rtl/pvr_classify.sv
module pvr_classify
    import pvr_pkg::*;
#(
    parameter  int N     = 64,
    parameter  int LANES = 4,
    localparam int IW    = $clog2(N),
    localparam int SW    = $clog2(N + 1),
    localparam int LB    = $clog2(LANES)
) (
    input  logic [IW-1:0] raw_row,
    input  logic [IW-1:0] col,
    input  logic [IW-1:0] trow,
    input  logic [SW-1:0] step,
    output route_e        kind,
    output logic [LB-1:0] lane
);

    logic raw_low;
    logic new_low;
    logic final_el;

    always_comb begin
        raw_low  = raw_row > col;
        new_low  = trow > col;
        final_el = (SW'(trow) < step) && (SW'(col) < step);
        if (final_el)              kind = RT_RETIRE;
        else if (raw_low != new_low) kind = RT_HOLD;
        else                       kind = RT_DIRECT;
        lane = trow[LB-1:0];
    end

endmodule

// File: rtl/pvr_hold_fifo.sv
module pvr_hold_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_s;

    ptr_s         p_q, p_d;
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        p_d   = p_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[p_q.wp] = push_data;
            p_d.wp        = p_q.wp + 1'b1;
        end
        if (pop) p_d.rp = p_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            p_q   <= p_d;
            mem_q <= mem_d;
        end
    end

    assign head  = mem_q[p_q.rp];
    assign empty = (p_q.cnt == '0);
    assign full  = (p_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/pivot_route_unit.sv
module pivot_route_unit
    import pvr_pkg::*;
#(
    parameter  int N          = 64,
    parameter  int LANES      = 4,
    parameter  int DW         = 16,
    parameter  int HOLD_DEPTH = 16,
    localparam int IW         = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IW-1:0]    in_row,
    input  logic [IW-1:0]    in_col,
    input  logic [DW-1:0]    in_data,
    input  logic             pv_we,
    input  logic [IW-1:0]    pv_a,
    input  logic [IW-1:0]    pv_b,
    input  logic             step_inc,
    input  logic [LANES-1:0] lane_rdy,
    output logic [LANES-1:0] out_vld,
    output logic [IW-1:0]    out_row,
    output logic [IW-1:0]    out_col,
    output logic [DW-1:0]    out_data,
    output logic             out_cross,
    output logic             ret_vld,
    output logic [IW-1:0]    ret_row,
    output logic [IW-1:0]    ret_col,
    output logic [DW-1:0]    ret_data
);

    localparam int SW = $clog2(N + 1);
    localparam int LB = $clog2(LANES);
    localparam int EW = 2 * IW + DW;

    typedef struct packed {
        logic [LANES-1:0] o_vld;
        logic [IW-1:0]    o_row;
        logic [IW-1:0]    o_col;
        logic [DW-1:0]    o_data;
        logic             o_cross;
        logic             r_vld;
        logic [IW-1:0]    r_row;
        logic [IW-1:0]    r_col;
        logic [DW-1:0]    r_data;
        logic [SW-1:0]    step;
    } state_s;

    state_s        st_q, st_d;
    logic [IW-1:0] trow;
    route_e        kind;
    logic [LB-1:0] in_lane;
    logic [EW-1:0] hd;
    logic          q_empty;
    logic          q_full;
    logic          accept;
    logic          direct;
    logic          push;
    logic          pop;
    logic [IW-1:0] hd_row;
    logic [IW-1:0] hd_col;
    logic [DW-1:0] hd_data;
    logic [LB-1:0] hd_lane;
    logic [SW-1:0] step_now;

    pvr_perm_table #(.N(N)) u_perm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_en  (pv_we),
        .sw_a   (pv_a),
        .sw_b   (pv_b),
        .rd_idx (in_row),
        .rd_val (trow)
    );

    pvr_classify #(.N(N), .LANES(LANES)) u_cls (
        .raw_row (in_row),
        .col     (in_col),
        .trow    (trow),
        .step    (st_q.step),
        .kind    (kind),
        .lane    (in_lane)
    );

    pvr_hold_fifo #(.W(EW), .DEPTH(HOLD_DEPTH)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({trow, in_col, in_data}),
        .pop       (pop),
        .head      (hd),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign {hd_row, hd_col, hd_data} = hd;
    assign hd_lane  = hd_row[LB-1:0];
    assign in_ready = !q_full;
    assign accept   = in_valid && !q_full;
    assign direct   = accept && (kind == RT_DIRECT);
    assign push     = accept && (kind == RT_HOLD);
    assign pop      = !q_empty && !direct && lane_rdy[hd_lane];
    assign step_now = st_q.step;

    always_comb begin
        st_d         = st_q;
        st_d.o_vld   = '0;
        st_d.o_cross = 1'b0;
        st_d.r_vld   = 1'b0;
        if (direct) begin
            st_d.o_vld[in_lane] = 1'b1;
            st_d.o_row          = trow;
            st_d.o_col          = in_col;
            st_d.o_data         = in_data;
        end else if (pop) begin
            st_d.o_vld[hd_lane] = 1'b1;
            st_d.o_row          = hd_row;
            st_d.o_col          = hd_col;
            st_d.o_data         = hd_data;
            st_d.o_cross        = 1'b1;
        end
        if (accept && kind == RT_RETIRE) begin
            st_d.r_vld  = 1'b1;
            st_d.r_row  = trow;
            st_d.r_col  = in_col;
            st_d.r_data = in_data;
        end
        if (step_inc && st_q.step != SW'(N)) st_d.step = st_q.step + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld   = st_q.o_vld;
    assign out_row   = st_q.o_row;
    assign out_col   = st_q.o_col;
    assign out_data  = st_q.o_data;
    assign out_cross = st_q.o_cross;
    assign ret_vld   = st_q.r_vld;
    assign ret_row   = st_q.r_row;
    assign ret_col   = st_q.r_col;
    assign ret_data  = st_q.r_data;

endmodule

// File: rtl/pru_check.sv
module pru_check #(
    parameter  int N     = 64,
    parameter  int LANES = 4,
    localparam int SW    = $clog2(N + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             step_inc,
    input logic [LANES-1:0] lane_rdy,
    input logic [LANES-1:0] out_vld,
    input logic             out_cross,
    input logic             ret_vld,
    input logic [SW-1:0]    step_now
);

    // R3
    lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_vld));

    // R7
    retire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld |-> !((|out_vld) && !out_cross));

    // R5
    held_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_vld) && out_cross) |-> (($past(lane_rdy) & out_vld) != '0));

    // R8
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid));

    // R9
    step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_now <= SW'(N));

    // R9
    step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_now != $past(step_now)) |-> $past(step_inc));

endmodule

bind pivot_route_unit pru_check #(.N(N), .LANES(LANES)) u_pru_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .step_inc  (step_inc),
    .lane_rdy  (lane_rdy),
    .out_vld   (out_vld),
    .out_cross (out_cross),
    .ret_vld   (ret_vld),
    .step_now  (step_now)
);

// File: tb/tb_pivot_route_unit.sv
module tb_pivot_route_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 64;
    localparam int L  = 4;
    localparam int DW = 16;
    localparam int QD = 16;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] in_row = '0;
    logic [IW-1:0] in_col = '0;
    logic [DW-1:0] in_data = '0;
    logic          pv_we = 1'b0;
    logic [IW-1:0] pv_a = '0;
    logic [IW-1:0] pv_b = '0;
    logic          step_inc = 1'b0;
    logic [L-1:0]  lane_rdy = '0;
    logic [L-1:0]  out_vld;
    logic [IW-1:0] out_row;
    logic [IW-1:0] out_col;
    logic [DW-1:0] out_data;
    logic          out_cross;
    logic          ret_vld;
    logic [IW-1:0] ret_row;
    logic [IW-1:0] ret_col;
    logic [DW-1:0] ret_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int perm [N];
    int qrow [QD];
    int qcol [QD];
    int qdat [QD];
    int qn = 0;
    int stp = 0;
    int dcount = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pivot_route_unit #(.N(N), .LANES(L), .DW(DW), .HOLD_DEPTH(QD)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_col(in_col), .in_data(in_data),
        .pv_we(pv_we), .pv_a(pv_a), .pv_b(pv_b), .step_inc(step_inc),
        .lane_rdy(lane_rdy), .out_vld(out_vld), .out_row(out_row),
        .out_col(out_col), .out_data(out_data), .out_cross(out_cross),
        .ret_vld(ret_vld), .ret_row(ret_row), .ret_col(ret_col), .ret_data(ret_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, predict, check at the next falling edge
    task automatic cyc(input bit v, input int r, input int c, input bit pw,
                       input int a, input int b, input bit inc, input int rdy);
        int  tr, lane, hlane, d;
        bit  acc, fin, crs, dir, pop;
        int  e_vld, e_row, e_col, e_dat, e_crs;
        string tag;
        d = (dcount * 37 + 11) & 16'hFFFF;
        dcount++;
        in_valid = v; in_row = IW'(r); in_col = IW'(c); in_data = DW'(d);
        pv_we = pw; pv_a = IW'(a); pv_b = IW'(b); step_inc = inc;
        lane_rdy = L'(rdy);
        #1;
        chk("R8 in_ready", int'(in_ready), (qn < QD) ? 1 : 0);
        tr  = perm[r];
        acc = v && (qn < QD);
        fin = (stp > tr) && (stp > c);
        crs = ((r > c) != (tr > c));
        dir = acc && !fin && !crs;
        hlane = (qn > 0) ? (qrow[0] % L) : 0;
        pop = (qn > 0) && !dir && rdy[hlane];
        e_vld = 0; e_row = 0; e_col = 0; e_dat = 0; e_crs = 0;
        if (dir) begin
            lane = tr % L;
            e_vld = 1 << lane; e_row = tr; e_col = c; e_dat = d;
            tag = ((qn > 0) && rdy[hlane]) ? "R6" : (crs ? "R4" : "R3");
        end else if (pop) begin
            e_vld = 1 << hlane; e_row = qrow[0]; e_col = qcol[0]; e_dat = qdat[0];
            e_crs = 1; tag = "R5";
        end else begin
            tag = (acc && crs && !fin) ? "R4" : "R3";
        end
        // model update
        if (pop) begin
            for (int k = 0; k < QD - 1; k++) begin
                qrow[k] = qrow[k+1]; qcol[k] = qcol[k+1]; qdat[k] = qdat[k+1];
            end
            qn--;
        end
        if (acc && !fin && crs) begin
            qrow[qn] = tr; qcol[qn] = c; qdat[qn] = d; qn++;
        end
        if (pw) begin
            int t;
            t = perm[a]; perm[a] = perm[b]; perm[b] = t;
        end
        if (inc && stp < N) stp++;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " out_vld"}, int'(out_vld), e_vld);
        if (e_vld != 0) begin
            chk("R2 out_row", int'(out_row), e_row);
            chk({tag, " out_col"}, int'(out_col), e_col);
            chk({tag, " out_data"}, int'(out_data), e_dat);
            chk({tag, " out_cross"}, int'(out_cross), e_crs);
        end
        chk("R7 ret_vld", int'(ret_vld), (acc && fin) ? 1 : 0);
        if (acc && fin) begin
            chk("R7 ret_row", int'(ret_row), tr);
            chk("R7 ret_col", int'(ret_col), c);
            chk("R7 ret_data", int'(ret_data), d);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) perm[i] = i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 ret_vld", int'(ret_vld), 0);
        // R1/R2/R3 identity sweep, step zero
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) cyc(1, r, c, 0, 0, 0, 0, 15);
        // R2 pivot records, same-edge use of old table
        cyc(1, 5, 3, 1, 0, 5, 0, 15);
        cyc(1, 5, 3, 1, 2, 9, 0, 15);
        cyc(1, 9, 4, 0, 0, 0, 0, 15);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, 0, 15);
        // R8 fill the holding queue with crossing elements, lanes not ready
        for (int k = 0; k < QD + 2; k++) cyc(1, (k % 2) ? 9 : 5, (k % 2) ? 4 : 3, 0, 0, 0, 0, 0);
        // R5 head on lane 0 drains, next head (lane 2) blocks
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 0, 0, 1);
        // R6 direct element against a ready head
        cyc(1, 1, 1, 0, 0, 0, 0, 15);
        cyc(1, 3, 2, 0, 0, 0, 0, 15);
        for (int k = 0; k < QD + 2; k++) cyc(0, 0, 0, 0, 0, 0, 0, 15);
        // R4 mixed sweep after exchanges
        for (int r = 0; r < 12; r++)
            for (int c = 0; c < 12; c++) cyc(1, r, c, 0, 0, 0, 0, (r + c) % 16);
        for (int k = 0; k < QD + 2; k++) cyc(0, 0, 0, 0, 0, 0, 0, 15);
        // R7/R9 advance step and sweep around the boundary
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, 1, 15);
        for (int r = 0; r < 10; r++)
            for (int c = 0; c < 10; c++) cyc(1, r, c, 0, 0, 0, 0, 15);
        for (int k = 0; k < QD + 2; k++) cyc(0, 0, 0, 0, 0, 0, 0, 15);
        // R9 saturation: far past N, all elements final
        for (int k = 0; k < 140; k++) cyc(0, 0, 0, 0, 0, 0, 1, 15);
        cyc(1, 63, 63, 0, 0, 0, 0, 15);
        cyc(1, 62, 5, 0, 0, 0, 0, 15);
        cyc(1, 0, 63, 0, 0, 0, 0, 15);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule